// File: doc/BRIEF.md
# Registered-Mode Output Macrocell

This block is one output cell of a small programmable AND-OR logic device that runs in its registered mode. The cell holds its own product-term array. Every term is the AND of a chosen set of true and complemented array inputs, picked by a static fuse mask, and every term can also be switched off on its own. The terms are ORed together and the result passes through a polarity stage. The cell then either clocks that result into a flip-flop on the shared device clock, or drives it straight to the pin.

Static configuration bits set the cell's form and polarity. Two global bits must hold the registered-mode pattern, or the pin enable stays low. A per-cell form bit chooses between two forms. The registered form sums eight terms into a flip-flop, takes its enable from the common enable pin, and feeds the flip-flop state back. The combinational form sums seven terms, uses the last term as its own tristate enable, and feeds back the value on the pin. The pin is modelled as a data value plus an enable, with a separate input for the value seen on the pin when something else drives it. The feedback output goes to the device routing, which carries it into the arrays of the cells.

Top module: `regmode_cell`

## Requirements
- R1: `pin_oe` is 0 whenever `cfg_sync` is 1 or `cfg_ac0` is 0, whatever the other inputs are.
- R2: `cfg_ac1`=0 selects the registered form and `cfg_ac1`=1 selects the combinational form.
- R3: With `cfg_xor`=1 the pin carries the cell's logic value unchanged (active high). With `cfg_xor`=0 it carries the complement (active low).
- R4: In the registered form, inside registered mode, `pin_oe` is 1 exactly when the shared active-low enable `common_oe_n` is 0.
- R5: In the registered form, the OR of all N_PT terms is captured on the rising clock edge, and `pin_out` shows it from that edge on. Changes to the inputs between edges do not reach `pin_out`.
- R6: In the combinational form, `pin_out` follows the OR of terms 0 to N_PT-2 in the same cycle. Term N_PT-1 does not contribute to it.
- R7: In the combinational form, inside registered mode, `pin_oe` equals the value of term N_PT-1.
- R8: Term t uses bits `fuse_mask[t*2*N_IN +: 2*N_IN]`. Within that field, bit 2i connects the true literal of `arr_in[i]` and bit 2i+1 connects its complement. A term with both literals of any input connected is 0. A term with no literal connected is 1.
- R9: When `pt_dis[t]` is 1, term t is 0 regardless of its mask.
- R10: `fb` is the flip-flop state (before polarity) in the registered form. In the combinational form it is `pin_out` while `pin_oe` is 1, and `pin_in` otherwise.
- R11: A synchronous `rst` clears the flip-flop, so after a reset edge a registered cell shows `fb`=0 and `pin_out`=!`cfg_xor`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared device clock, rising edge |
| rst | input | 1 | Synchronous clear of the flip-flop (simulation initialisation) |
| cfg_sync | input | 1 | Global mode bit, must be 0 for registered mode |
| cfg_ac0 | input | 1 | Global mode bit, must be 1 for registered mode |
| cfg_ac1 | input | 1 | Cell form: 0 registered, 1 combinational |
| cfg_xor | input | 1 | Polarity: 1 active high, 0 active low |
| fuse_mask | input | N_PT*2*N_IN | Literal connections of all product terms |
| pt_dis | input | N_PT | Per-term disable |
| common_oe_n | input | 1 | Shared active-low output enable of registered cells |
| arr_in | input | N_IN | Array inputs from device routing |
| pin_in | input | 1 | Value seen on the pin when the cell does not drive it |
| pin_out | output | 1 | Data the cell drives onto the pin |
| pin_oe | output | 1 | Pin drive enable |
| fb | output | 1 | Feedback into the device routing |

## Verification
The bench first pins down the term corner cases. A term with both literals of one input connected must read 0, an empty term must read 1, and a disabled empty term must read 0. A design that ORed the literals instead of ANDing them, or that ignored the disable, would leave the pin high in those steps. Other directed steps target the enable term. In the combinational form, a design that let term N_PT-1 into the sum would drive a 1 where 0 is expected. A design that used the common enable pin in that form would get `pin_oe` wrong, and a design that fed back the driven value while the enable is off would return the wrong `fb`. A one-cycle latency step catches a registered form that bypasses the flip-flop. Long random runs then vary the masks, the mode bits, including patterns outside registered mode, the polarity and the enable, to expose inversion slips and a missing mode gate.

// File: rtl/regmode_cell.sv
module regmode_cell #(
  parameter int N_IN = 8,
  parameter int N_PT = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_sync,
  input  logic                   cfg_ac0,
  input  logic                   cfg_ac1,
  input  logic                   cfg_xor,
  input  logic [N_PT*2*N_IN-1:0] fuse_mask,
  input  logic [N_PT-1:0]        pt_dis,
  input  logic                   common_oe_n,
  input  logic [N_IN-1:0]        arr_in,
  input  logic                   pin_in,
  output logic                   pin_out,
  output logic                   pin_oe,
  output logic                   fb
);
  localparam int TW   = 2 * N_IN;
  localparam int EN_T = N_PT - 1;

  logic [N_PT-1:0] pt;
  logic            q;
  logic            mode_ok;
  logic            sum_all;
  logic            sum_comb;
  logic            src;

  genvar t, i;
  generate
    for (t = 0; t < N_PT; t++) begin : g_term
      logic [TW-1:0]   m;
      logic [N_IN-1:0] kill;
      assign m = fuse_mask[t*TW +: TW];
      for (i = 0; i < N_IN; i++) begin : g_lit
        assign kill[i] = (m[2*i] & ~arr_in[i]) | (m[2*i+1] & arr_in[i]);
      end
      assign pt[t] = ~pt_dis[t] & ~(|kill);
    end
  endgenerate

  assign mode_ok  = ~cfg_sync & cfg_ac0;
  assign sum_all  = |pt;
  assign sum_comb = |pt[EN_T-1:0];

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= sum_all;
  end

  assign src     = cfg_ac1 ? sum_comb : q;
  assign pin_out = cfg_xor ? src : ~src;
  assign pin_oe  = mode_ok & (cfg_ac1 ? pt[EN_T] : ~common_oe_n);
  assign fb      = cfg_ac1 ? (pin_oe ? pin_out : pin_in) : q;
endmodule

// File: rtl/regmode_cell_chk.sv
module regmode_cell_chk (
  input logic clk,
  input logic rst,
  input logic cfg_sync,
  input logic cfg_ac0,
  input logic cfg_ac1,
  input logic cfg_xor,
  input logic common_oe_n,
  input logic pin_in,
  input logic pin_out,
  input logic pin_oe,
  input logic fb
);
  AST_OE_GATED: assert property (@(posedge clk) disable iff (rst) (cfg_sync || !cfg_ac0) |-> !pin_oe); // R1
  AST_REG_OE: assert property (@(posedge clk) disable iff (rst) (!cfg_sync && cfg_ac0 && !cfg_ac1) |-> (pin_oe == !common_oe_n)); // R4
  AST_REG_POLARITY: assert property (@(posedge clk) disable iff (rst) !cfg_ac1 |-> (pin_out == (cfg_xor ? fb : !fb))); // R3
  AST_COMB_FB_DRIVEN: assert property (@(posedge clk) disable iff (rst) (cfg_ac1 && pin_oe) |-> (fb == pin_out)); // R10
  AST_COMB_FB_INPUT: assert property (@(posedge clk) disable iff (rst) (cfg_ac1 && !pin_oe) |-> (fb == pin_in)); // R10
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (cfg_ac1 || !fb)); // R11
endmodule

bind regmode_cell regmode_cell_chk u_chk (
  .clk(clk), .rst(rst), .cfg_sync(cfg_sync), .cfg_ac0(cfg_ac0),
  .cfg_ac1(cfg_ac1), .cfg_xor(cfg_xor), .common_oe_n(common_oe_n),
  .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .fb(fb)
);

// File: tb/regmode_cell_tb.sv
module regmode_cell_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_IN = 8;
  localparam int N_PT = 8;
  localparam int TW = 2 * N_IN;

  logic clk = 1'b0;
  logic b_rst = 1'b1;
  logic b_sync = 1'b0, b_ac0 = 1'b1, b_ac1 = 1'b0, b_xor = 1'b0;
  logic [N_PT*TW-1:0] b_mask = '0;
  logic [N_PT-1:0] b_dis = '1;
  logic b_oen = 1'b0;
  logic [N_IN-1:0] b_x = '0;
  logic b_pin = 1'b0;
  logic pin_out, pin_oe, fb;

  int n_chk = 0, n_fail = 0;
  bit ref_q = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regmode_cell #(.N_IN(N_IN), .N_PT(N_PT)) u_dut (
    .clk(clk), .rst(b_rst), .cfg_sync(b_sync), .cfg_ac0(b_ac0),
    .cfg_ac1(b_ac1), .cfg_xor(b_xor), .fuse_mask(b_mask), .pt_dis(b_dis),
    .common_oe_n(b_oen), .arr_in(b_x), .pin_in(b_pin),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb(fb)
  );

  function automatic bit term_val(int t);
    if (b_dis[t]) return 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      if (b_mask[t*TW + 2*i] && !b_x[i]) return 1'b0;
      if (b_mask[t*TW + 2*i + 1] && b_x[i]) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic bit sum_of(int n);
    for (int t = 0; t < n; t++) if (term_val(t)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit exp_oe();
    if (b_sync || !b_ac0) return 1'b0;
    return b_ac1 ? term_val(N_PT-1) : !b_oen;
  endfunction

  function automatic bit exp_data();
    bit s;
    s = b_ac1 ? sum_of(N_PT-1) : ref_q;
    return b_xor ? s : !s;
  endfunction

  function automatic bit exp_fb();
    if (!b_ac1) return ref_q;
    return exp_oe() ? exp_data() : b_pin;
  endfunction

  task automatic chk(input logic act, input bit exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk(pin_oe, exp_oe(), "R1/R4/R7 pin_oe");
    if (exp_oe()) chk(pin_out, exp_data(), "R2/R3/R5/R6 pin_out");
    chk(fb, exp_fb(), "R10 fb");
  endtask

  task automatic tick();
    bit nx;
    nx = b_rst ? 1'b0 : sum_of(N_PT);
    @(posedge clk);
    ref_q = nx;
    @(negedge clk);
  endtask

  task automatic clean();
    b_sync = 0; b_ac0 = 1; b_mask = '0; b_dis = '1; b_oen = 0;
  endtask

  function automatic logic [N_PT*TW-1:0] rand_mask();
    logic [N_PT*TW-1:0] m = '0;
    for (int t = 0; t < N_PT; t++)
      for (int i = 0; i < N_IN; i++) begin
        int r = $urandom_range(0, 15);
        if (r == 12 || r == 13) m[t*TW + 2*i] = 1'b1;
        else if (r == 14) m[t*TW + 2*i + 1] = 1'b1;
        else if (r == 15 && $urandom_range(0, 3) == 0) begin
          m[t*TW + 2*i] = 1'b1; m[t*TW + 2*i + 1] = 1'b1;
        end
      end
    return m;
  endfunction

  initial begin : wdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    @(negedge clk);
    b_rst = 1; b_ac1 = 0; b_xor = 0; clean();
    tick(); tick();
    chk(fb, 1'b0, "R11 reset fb");
    chk(pin_out, 1'b1, "R11 reset pin_out active low");
    b_rst = 0;

    // R8: both literals of one input -> 0; empty term -> 1
    b_ac1 = 1; b_xor = 1; b_dis = '0; b_mask = '0;
    b_dis[6:1] = '1;
    b_mask[0] = 1'b1; b_mask[1] = 1'b1; b_x = 8'hA5;
    #1; chk(pin_out, 1'b0, "R8 both literals"); chk(pin_oe, 1'b1, "R8 empty enable term");
    @(negedge clk);
    b_mask[1:0] = 2'b00; #1; chk(pin_out, 1'b1, "R8 empty term");
    @(negedge clk);
    b_mask[0] = 1'b1; b_x[0] = 1'b0; #1; chk(pin_out, 1'b0, "R8 true literal low");
    b_x[0] = 1'b1; #1; chk(pin_out, 1'b1, "R8 true literal high");
    b_mask[0] = 1'b0; b_mask[1] = 1'b1; #1; chk(pin_out, 1'b0, "R8 complement literal");
    @(negedge clk);
    // R9: disabled empty term
    b_mask[1:0] = 2'b00; b_dis[0] = 1'b1; #1; chk(pin_out, 1'b0, "R9 disable");
    // R6: only enable term live -> data 0
    chk(pin_oe, 1'b1, "R7 term on"); chk(pin_out, 1'b0, "R6 enable term excluded");
    // R7 and R10: enable term off, feedback from pin_in
    @(negedge clk);
    b_dis[N_PT-1] = 1'b1; b_pin = 1'b1; b_oen = 1'b0; #1;
    chk(pin_oe, 1'b0, "R7 term off ignores common enable");
    chk(fb, 1'b1, "R10 fb from pin_in");
    b_pin = 1'b0; #1; chk(fb, 1'b0, "R10 fb from pin_in low");
    // R1
    @(negedge clk);
    b_dis[N_PT-1] = 1'b0; b_sync = 1; #1; chk(pin_oe, 1'b0, "R1 sync set");
    b_sync = 0; b_ac0 = 0; #1; chk(pin_oe, 1'b0, "R1 ac0 clear");
    b_ac0 = 1;

    // R5: registered one-cycle latency
    tick();
    clean(); b_ac1 = 0; b_xor = 1; b_dis[0] = 1'b0;
    #1; chk(pin_out, ref_q, "R5 before edge");
    tick();
    chk(pin_out, 1'b1, "R5 captured one");
    b_dis[0] = 1'b1; #1; chk(pin_out, 1'b1, "R5 holds between edges");
    tick();
    chk(pin_out, 1'b0, "R5 captured zero");
    b_oen = 1; #1; chk(pin_oe, 1'b0, "R4 common enable off");
    b_oen = 0; #1; chk(pin_oe, 1'b1, "R4 common enable on");

    // random
    for (int blk = 0; blk < 400; blk++) begin
      b_mask = rand_mask();
      b_dis = N_PT'($urandom) & N_PT'($urandom);
      b_ac1 = 1'($urandom); b_xor = 1'($urandom);
      b_sync = ($urandom_range(0, 7) == 0);
      b_ac0 = ($urandom_range(0, 7) != 0);
      for (int c = 0; c < 25; c++) begin
        b_x = N_IN'($urandom); b_pin = 1'($urandom); b_oen = 1'($urandom);
        #1; cmp_all();
        tick();
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule